// File: doc/BRIEF.md
# Fast CPU Reset and A20 Gate Controller

This block is a small system-control register that gives software a quick path to reset the processor and to force the A20 address-mask line. The register is two bits wide. Writing a 1 into the reset bit while it holds 0 starts a timed sequence. The sequence first waits a fixed delay and then drives a one-shot active-low pulse of fixed width. That pulse is merged with the keyboard-controller reset, and the merged reset leaves the block with a polarity that is chosen by a configuration input. The second bit drives an alternate A20 signal. That signal is ORed with the keyboard-controller A20 gate to form the mask output to the processor.

Both the delay and the pulse width are given in nanoseconds, together with the clock frequency. They are converted to whole clock cycles when the block is built, rounding up, so that each minimum time is always met. An enable input gates the whole register. While it is low, writes do nothing and reads return zero.

Top module: `fast_reset_a20`

## Requirements
- R1: After reset, both register bits are 0, the internal alternate reset is high (inactive), and the alternate A20 signal is low.
- R2: A write with bit 0 = 1, while the port is enabled and bit 0 holds 0, drives the alternate reset low. The low starts exactly DELAY_CYC clock edges after the write edge and lasts exactly PULSE_CYC cycles.
- R3: While bit 0 stays 1, further writes of 1 to it produce no pulse. After bit 0 is written to 0, a new write of 1 produces a new pulse.
- R4: Writing bit 0 back to 0 during the delay or the pulse does not shorten or cancel the sequence that is running.
- R5: A write that sets bit 0 from 0 to 1 while a sequence is still running is dropped and produces no second pulse.
- R6: While port_en is 0, writes change neither register bit, and rd_data reads 0.
- R7: While port_en is 1, rd_data bit 0 is the reset bit, rd_data bit 1 is the A20 bit, and all higher bits are 0.
- R8: The combined reset is the AND of the alternate reset and kbd_rst_n, both active low. rst_out carries it unchanged when rst_pol is 0 and inverted when rst_pol is 1.
- R9: Bit 1 is written directly, and a20_out = bit 1 OR kbd_a20.
- R10: DELAY_CYC and PULSE_CYC equal ceil(time_ns × CLK_MHZ / 1000), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_en | input | 1 | Register enable from the configuration register |
| wr_valid | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | DW | Write data; bit 0 is the reset bit, bit 1 is the A20 bit |
| rd_data | output | DW | Read data |
| kbd_rst_n | input | 1 | Keyboard-controller reset, active low |
| kbd_a20 | input | 1 | Keyboard-controller A20 gate |
| rst_pol | input | 1 | 0: rst_out active low, 1: rst_out active high |
| rst_out | output | 1 | Combined processor reset |
| a20_out | output | 1 | A20 mask output to the processor |

## Verification
The bench builds the block with CLK_MHZ = 125, DELAY_NS = 200 and PULSE_NS = 100. That gives a 25-cycle delay and a 12.5-cycle width, which rounds up to 13. The short windows let the bench measure the delay, the width, the re-arm rule, a clear during the sequence and a dropped trigger, each in a few dozen cycles. The odd width also exercises the rounding. The default microsecond timings are kept for real builds.

// File: rtl/fra_pkg.sv
package fra_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_LOW  = 2'd2
  } seq_state_e;

  // Round a time in ns up to whole cycles of a clock given in MHz; never below 1.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/fra_regs.sv
module fra_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          wr_valid,
  input  logic [1:0]    wr_bits,
  output logic          rst_bit,
  output logic          a20_bit,
  output logic          arm,
  output logic [DW-1:0] rd_data
);

  logic wr_acc;
  logic rst_bit_d, a20_bit_d;

  assign wr_acc = wr_valid & port_en;
  // A 0 -> 1 transition of the reset bit requests a new sequence.
  assign arm    = wr_acc & wr_bits[0] & ~rst_bit;

  always_comb begin
    rst_bit_d = rst_bit;
    a20_bit_d = a20_bit;
    if (wr_acc) begin
      rst_bit_d = wr_bits[0];
      a20_bit_d = wr_bits[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_bit <= 1'b0;
      a20_bit <= 1'b0;
    end else if (wr_acc) begin
      rst_bit <= rst_bit_d;
      a20_bit <= a20_bit_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (port_en) begin
      rd_data[0] = rst_bit;
      rd_data[1] = a20_bit;
    end
  end

endmodule

// File: rtl/fra_pulse_seq.sv
module fra_pulse_seq
  import fra_pkg::*;
#(
  parameter int D_CYC = 1,
  parameter int P_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic alt_rst_n
);

  localparam int MAXC  = (D_CYC > P_CYC) ? D_CYC : P_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(D_CYC - 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(P_CYC - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             low_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (arm) begin
          st_d  = SEQ_WAIT;
          cnt_d = '0;
        end
      end
      SEQ_WAIT: begin
        if (cnt_q == D_LAST) begin
          st_d  = SEQ_LOW;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      SEQ_LOW: begin
        if (cnt_q == P_LAST) begin
          st_d  = SEQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = SEQ_IDLE;
        cnt_d = '0;
      end
    endcase
    low_d = (st_d == SEQ_LOW);
  end

  // The output is registered so that it cannot glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      cnt_q     <= '0;
      alt_rst_n <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      alt_rst_n <= ~low_d;
    end
  end

endmodule

// File: rtl/fra_out_merge.sv
module fra_out_merge (
  input  logic alt_rst_n,
  input  logic kbd_rst_n,
  input  logic rst_pol,
  input  logic alt_a20,
  input  logic kbd_a20,
  output logic rst_out,
  output logic a20_out
);

  logic merged_n;

  assign merged_n = alt_rst_n & kbd_rst_n;
  assign rst_out  = rst_pol ? ~merged_n : merged_n;
  assign a20_out  = alt_a20 | kbd_a20;

endmodule

// File: rtl/fast_reset_a20.sv
module fast_reset_a20
  import fra_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CLK_MHZ  = 125,
  parameter int DELAY_NS = 14000,
  parameter int PULSE_NS = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          kbd_rst_n,
  input  logic          kbd_a20,
  input  logic          rst_pol,
  output logic          rst_out,
  output logic          a20_out
);

  localparam int D_CYC = ns_to_cyc(DELAY_NS, CLK_MHZ);
  localparam int P_CYC = ns_to_cyc(PULSE_NS, CLK_MHZ);

  logic rst_bit, a20_bit, arm, alt_rst_n;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DW-1:2];

  fra_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .wr_valid(wr_valid),
    .wr_bits (wr_data[1:0]),
    .rst_bit (rst_bit),
    .a20_bit (a20_bit),
    .arm     (arm),
    .rd_data (rd_data)
  );

  fra_pulse_seq #(.D_CYC(D_CYC), .P_CYC(P_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .alt_rst_n(alt_rst_n)
  );

  fra_out_merge u_merge (
    .alt_rst_n(alt_rst_n),
    .kbd_rst_n(kbd_rst_n),
    .rst_pol  (rst_pol),
    .alt_a20  (a20_bit),
    .kbd_a20  (kbd_a20),
    .rst_out  (rst_out),
    .a20_out  (a20_out)
  );

endmodule

// File: rtl/fra_checker.sv
module fra_checker #(
  parameter int P_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic wr_valid,
  input logic alt_rst_n,
  input logic a20_bit,
  input logic rst_bit,
  input logic kbd_rst_n,
  input logic kbd_a20,
  input logic rst_pol,
  input logic rst_out,
  input logic a20_out
);

  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else        low_cnt <= alt_rst_n ? 32'd0 : low_cnt + 32'd1;
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alt_rst_n) |-> (low_cnt == 32'(P_CYC)));

  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= 32'(P_CYC));

  assert_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && wr_valid) |=> ($stable(a20_bit) && $stable(rst_bit)));

  assert_merge_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pol && !kbd_rst_n) |-> !rst_out);

  assert_merge_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pol && !alt_rst_n) |-> rst_out);

  assert_a20_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a20_bit || kbd_a20) |-> a20_out);

endmodule

bind fast_reset_a20 fra_checker #(.P_CYC(P_CYC)) u_fra_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .port_en  (port_en),
  .wr_valid (wr_valid),
  .alt_rst_n(alt_rst_n),
  .a20_bit  (a20_bit),
  .rst_bit  (rst_bit),
  .kbd_rst_n(kbd_rst_n),
  .kbd_a20  (kbd_a20),
  .rst_pol  (rst_pol),
  .rst_out  (rst_out),
  .a20_out  (a20_out)
);

// File: tb/fast_reset_a20_bench.sv
`timescale 1ns/1ps
module fast_reset_a20_bench;

  localparam int DW       = 8;
  localparam int CLK_MHZ  = 125;
  localparam int DELAY_NS = 200;
  localparam int PULSE_NS = 100;

  function automatic int exp_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  localparam int ED = exp_cyc(DELAY_NS, CLK_MHZ);  // 25
  localparam int EP = exp_cyc(PULSE_NS, CLK_MHZ);  // 13

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          port_en = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          kbd_rst_n = 1'b1;
  logic          kbd_a20 = 1'b0;
  logic          rst_pol = 1'b0;
  logic          rst_out;
  logic          a20_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fast_reset_a20 #(
    .DW(DW), .CLK_MHZ(CLK_MHZ), .DELAY_NS(DELAY_NS), .PULSE_NS(PULSE_NS)
  ) u_fast_reset_a20 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_data(rd_data), .kbd_rst_n(kbd_rst_n),
    .kbd_a20(kbd_a20), .rst_pol(rst_pol), .rst_out(rst_out), .a20_out(a20_out)
  );

  // Negedge monitor of rst_out (used with rst_pol=0, kbd_rst_n=1).
  int neg_cnt = 0;
  int fall_at = 0;
  int rise_at = 0;
  int pulses = 0;
  bit prev_hi = 1'b1;

  always @(negedge clk) begin
    neg_cnt = neg_cnt + 1;
    if (prev_hi && !rst_out) begin
      fall_at = neg_cnt;
      pulses  = pulses + 1;
    end
    if (!prev_hi && rst_out) rise_at = neg_cnt;
    prev_hi = rst_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [DW-1:0] d, output int wc);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    wc = neg_cnt;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] exp_rd(input bit en, input bit b0, input bit b1);
    logic [DW-1:0] r;
    r = '0;
    if (en) begin
      r[0] = b0;
      r[1] = b1;
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wc, pc;
    bit m_a20;
    void'($urandom(32'd20240611));
    port_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
    chk(rst_out == 1'b1, "R1 rst_out", int'(rst_out), 1);
    chk(a20_out == 1'b0, "R1 a20_out", int'(a20_out), 0);
    chk(pulses == 0, "R1 pulses", pulses, 0);

    // R2 / R10: delay and width
    pc = pulses;
    do_write(8'h01, wc);
    repeat (ED + EP + 4) @(negedge clk);
    chk(pulses == pc + 1, "R2 pulse count", pulses, pc + 1);
    chk(fall_at - wc - 1 == ED, "R2 delay cycles", fall_at - wc - 1, ED);
    chk(rise_at - fall_at == EP, "R10 width rounds up", rise_at - fall_at, EP);
    chk(rd_data == 8'h01, "R7 rd_data bit0", int'(rd_data), 1);

    // R3: no re-fire while bit 0 stays 1
    pc = pulses;
    do_write(8'h01, wc);
    repeat (ED + EP + 4) @(negedge clk);
    chk(pulses == pc, "R3 no re-fire", pulses, pc);
    do_write(8'h00, wc);
    do_write(8'h01, wc);
    repeat (ED + EP + 4) @(negedge clk);
    chk(pulses == pc + 1, "R3 re-arm pulse", pulses, pc + 1);
    chk(fall_at - wc - 1 == ED, "R3 re-arm delay", fall_at - wc - 1, ED);

    // R4: clear during the delay does not cancel
    do_write(8'h00, wc);
    pc = pulses;
    do_write(8'h01, wc);
    repeat (2) @(negedge clk);
    begin int w2; do_write(8'h00, w2); end
    repeat (ED + EP + 4) @(negedge clk);
    chk(pulses == pc + 1, "R4 pulse kept", pulses, pc + 1);
    chk(fall_at - wc - 1 == ED, "R4 delay kept", fall_at - wc - 1, ED);
    chk(rise_at - fall_at == EP, "R4 width kept", rise_at - fall_at, EP);

    // R4: clear during the low phase does not shorten it
    pc = pulses;
    do_write(8'h01, wc);
    repeat (ED + 2) @(negedge clk);
    begin int w3; do_write(8'h00, w3); end
    repeat (EP + 4) @(negedge clk);
    chk(rise_at - fall_at == EP, "R4 width after clear in pulse", rise_at - fall_at, EP);

    // R5: trigger during a running sequence is dropped
    pc = pulses;
    do_write(8'h01, wc);
    repeat (2) @(negedge clk);
    begin int w4; do_write(8'h00, w4); do_write(8'h01, w4); end
    repeat (2 * (ED + EP) + 4) @(negedge clk);
    chk(pulses == pc + 1, "R5 dropped trigger", pulses, pc + 1);
    chk(rd_data == 8'h01, "R5 rd_data bit0", int'(rd_data), 1);

    // R6: disabled port ignores writes and reads 0
    do_write(8'h00, wc);
    port_en = 1'b0;
    @(negedge clk);
    chk(rd_data == '0, "R6 read while disabled", int'(rd_data), 0);
    pc = pulses;
    do_write(8'h03, wc);
    repeat (ED + EP + 4) @(negedge clk);
    chk(pulses == pc, "R6 no pulse while disabled", pulses, pc);
    chk(a20_out == 1'b0, "R6 a20 unchanged", int'(a20_out), 0);
    port_en = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R6 bits unchanged", int'(rd_data), 0);

    // R9 directed
    do_write(8'h02, wc);
    chk(a20_out == 1'b1, "R9 bit1 forces a20", int'(a20_out), 1);
    chk(rd_data == 8'h02, "R7 rd_data bit1", int'(rd_data), 2);
    do_write(8'h00, wc);
    kbd_a20 = 1'b1;
    @(negedge clk);
    chk(a20_out == 1'b1, "R9 kbd gate", int'(a20_out), 1);
    kbd_a20 = 1'b0;

    // R8: polarity during a live pulse
    rst_pol = 1'b1;
    do_write(8'h01, wc);
    repeat (ED + 1) @(negedge clk);
    chk(rst_out == 1'b1, "R8 inverted during pulse", int'(rst_out), 1);
    repeat (EP + 2) @(negedge clk);
    chk(rst_out == 1'b0, "R8 inverted idle", int'(rst_out), 0);
    rst_pol = 1'b0;
    do_write(8'h00, wc);

    // Random phase: R7, R8, R9 against a bench model (bit 0 kept 0)
    m_a20 = 1'b0;
    for (int i = 0; i < 300; i++) begin
      bit wv, b1;
      @(negedge clk);
      port_en   = ($urandom % 4) != 0;
      kbd_rst_n = $urandom % 2;
      kbd_a20   = $urandom % 2;
      rst_pol   = $urandom % 2;
      wv        = $urandom % 2;
      b1        = $urandom % 2;
      wr_valid  = wv;
      wr_data   = {DW'($urandom)} & ~DW'(1);
      wr_data[1] = b1;
      @(negedge clk);
      wr_valid = 1'b0;
      if (wv && port_en) m_a20 = b1;
      chk(rd_data == exp_rd(port_en, 1'b0, m_a20), "R7 random read",
          int'(rd_data), int'(exp_rd(port_en, 1'b0, m_a20)));
      chk(a20_out == (m_a20 | kbd_a20), "R9 random a20",
          int'(a20_out), int'(m_a20 | kbd_a20));
      chk(rst_out == (rst_pol ? ~kbd_rst_n : kbd_rst_n), "R8 random merge",
          int'(rst_out), int'(rst_pol ? ~kbd_rst_n : kbd_rst_n));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule